// File: doc/BRIEF.md
# SPI host frame and select control

This block holds the programmable state of an SPI host core and sequences it around the serial shift engine. Software reaches it through a small write/read register port. It keeps a 32-bit target frame count and a running count of finished frames. It raises a one-cycle completion pulse when the running count reaches the target. It also holds the frame size, and it decides what the slave-select lines show.

The shift engine reports each finished frame with a single-cycle pulse. It also reports whether its transmit FIFO is empty. In hardware select mode the selects assert while data is queued. When sticky select is set, they stay asserted through FIFO underruns until the last frame of the message completes. In direct mode the select register drives the lines verbatim.

Software loads the target count in two halves. The low half goes through the control register, which also restarts the running count. The high half goes through a separate register that leaves the low half alone. The frame size can only be changed while the core is disabled, and the SCLK/MOSI drivers are released while it is disabled.

Top module: `spi_frame_sel_ctl`

## Requirements
- R1: After reset: control, frame-size, select and upper-count registers read 0, 8, 0 and 0. The running count is 0, `sel_o` is all ones, `sel_oe_o` and `bus_oe_o` are 0, and `fifo_depth_o` is 8.
- R2: A write to address 0 (control) takes bit 0 as enable, bit 1 as hold-reset, bit 2 as sticky select and bit 3 as big FIFO, and takes bits 31:16 as target bits 15:0. Reading address 0 returns {target[15:0], 12'b0, big, sticky, hold, enable}.
- R3: A write to address 3 (upper count) loads target bits 31:16 from write-data bits 31:16 and leaves target bits 15:0 unchanged. Reading address 3 returns the whole 32-bit target.
- R4: A control write, or a write to address 1 (command) with bit 0 set, zeroes the running count at that clock edge. The command register reads as 0.
- R5: Each `frame_done_i` pulse raises the running count by one at the next edge while enable is 1 and hold-reset is 0. With enable at 0 the pulse has no effect.
- R6: `done_o` is high for exactly the one cycle that follows the frame pulse that brings the running count equal to the target.
- R7: While hold-reset is set, the running count stays 0, `done_o` stays low, and hardware-mode selects stay inactive (all ones).
- R8: A write to address 2 (frame size, low 6 bits) is ignored while enable is 1 and accepted while enable is 0.
- R9: `bus_oe_o` equals the enable bit, so SCLK and MOSI are tristated while the core is disabled.
- R10: With select-register bit 8 (direct) set, `sel_o` equals select-register bits 7:0 as written, whatever the enable and FIFO state.
- R11: In hardware mode without sticky select, `sel_o` is ~bits[7:0] in any cycle where enable is 1, hold is 0 and `txfifo_empty_i` is 0. Otherwise it is all ones.
- R12: In hardware mode with sticky select, once the FIFO has been non-empty the selects remain asserted while it is empty. They release in the cycle after the frame pulse that completes the target count.
- R13: `sel_oe_o` equals select-register bit 9.
- R14: `fifo_depth_o` is 32 while the big-FIFO bit is set and 8 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address for writes and reads |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| frame_done_i | input | 1 | One-cycle pulse per frame finished by the shift engine |
| txfifo_empty_i | input | 1 | Transmit FIFO empty flag |
| frame_count_o | output | 32 | Running frame count |
| done_o | output | 1 | Target count reached pulse |
| frame_size_o | output | 6 | Programmed frame size |
| fifo_depth_o | output | 6 | FIFO depth in frames |
| bus_oe_o | output | 1 | Drive enable for SCLK and MOSI |
| sel_o | output | 8 | Slave-select lines |
| sel_oe_o | output | 1 | Slave-select drive enable |

## Verification
Register reads are combinational on the address, so they are valid in the same cycle. A register write shows up just after the clock edge that takes it. The running count and the completion pulse change one edge after the frame pulse. Hardware-mode selects follow the FIFO flag in the same cycle, and a sticky select releases one edge after the final frame pulse. The bench drives inputs on the falling edge and reads directed results 1 ns later. A reference model, updated on the same rising edges, is compared against every output 4 ns after each rising edge, when every result for that cycle has settled.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_CMD   = 3'd1;
    localparam logic [2:0] A_FSIZE = 3'd2;
    localparam logic [2:0] A_CNTHI = 3'd3;
    localparam logic [2:0] A_SEL   = 3'd4;

    typedef struct packed {
        logic big_fifo;
        logic sticky;
        logic hold_rst;
        logic en;
    } ctrl_t;
endpackage

// File: rtl/sfs_regs.sv
module sfs_regs
    import sfs_pkg::*;
#(
    parameter int NSEL      = 8,
    parameter int FSIZE_W   = 6,
    parameter int FSIZE_RST = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [2:0]         addr_i,
    input  logic [31:0]        wdata_i,
    output logic [31:0]        rdata_o,
    output ctrl_t              ctrl_o,
    output logic [31:0]        target_o,
    output logic [FSIZE_W-1:0] fsize_o,
    output logic [NSEL-1:0]    bits_o,
    output logic               direct_o,
    output logic               oe_o,
    output logic               clr_o
);
    typedef struct packed {
        ctrl_t              ctrl;
        logic [31:0]        target;
        logic [FSIZE_W-1:0] fsize;
        logic [NSEL-1:0]    bits;
        logic               direct;
        logic               oe;
    } regs_t;

    regs_t r_d, r_q;
    logic  unused_wbits;
    assign unused_wbits = ^wdata_i;

    always_comb begin
        r_d = r_q;
        if (we_i) begin
            case (addr_i)
                A_CTRL: begin
                    r_d.ctrl.en       = wdata_i[0];
                    r_d.ctrl.hold_rst = wdata_i[1];
                    r_d.ctrl.sticky   = wdata_i[2];
                    r_d.ctrl.big_fifo = wdata_i[3];
                    r_d.target[15:0]  = wdata_i[31:16];
                end
                A_FSIZE: if (!r_q.ctrl.en) r_d.fsize = wdata_i[FSIZE_W-1:0];
                A_CNTHI: r_d.target[31:16] = wdata_i[31:16];
                A_SEL: begin
                    r_d.bits   = wdata_i[NSEL-1:0];
                    r_d.direct = wdata_i[NSEL];
                    r_d.oe     = wdata_i[NSEL+1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.fsize <= FSIZE_W'(FSIZE_RST);
        end else begin
            r_q <= r_d;
        end
    end

    assign clr_o = we_i && ((addr_i == A_CTRL) || (addr_i == A_CMD && wdata_i[0]));

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CTRL: rdata_o = {r_q.target[15:0], 12'b0, r_q.ctrl.big_fifo,
                               r_q.ctrl.sticky, r_q.ctrl.hold_rst, r_q.ctrl.en};
            A_FSIZE: rdata_o[FSIZE_W-1:0] = r_q.fsize;
            A_CNTHI: rdata_o = r_q.target;
            A_SEL: begin
                rdata_o[NSEL-1:0] = r_q.bits;
                rdata_o[NSEL]     = r_q.direct;
                rdata_o[NSEL+1]   = r_q.oe;
            end
            default: rdata_o = '0;
        endcase
    end

    assign ctrl_o   = r_q.ctrl;
    assign target_o = r_q.target;
    assign fsize_o  = r_q.fsize;
    assign bits_o   = r_q.bits;
    assign direct_o = r_q.direct;
    assign oe_o     = r_q.oe;

    // R8: frame size frozen while enabled
    a_r8_fsize_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == A_FSIZE && ctrl_o.en) |=> $stable(fsize_o));

    // R3: upper-count write keeps the low half
    a_r3_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == A_CNTHI) |=> (target_o[15:0] == $past(target_o[15:0])));
endmodule

// File: rtl/sfs_frame_counter.sv
module sfs_frame_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             hold_i,
    input  logic             clr_i,
    input  logic             frame_done_i,
    input  logic [CNT_W-1:0] target_i,
    output logic [CNT_W-1:0] count_o,
    output logic             done_o,
    output logic             last_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } cnt_st_t;

    cnt_st_t s_d, s_q;

    assign last_o = run_i && !hold_i && !clr_i && frame_done_i &&
                    ((s_q.cnt + CNT_W'(1)) == target_i);

    always_comb begin
        s_d      = s_q;
        s_d.done = last_o;
        if (hold_i || clr_i)            s_d.cnt = '0;
        else if (run_i && frame_done_i) s_d.cnt = s_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count_o = s_q.cnt;
    assign done_o  = s_q.done;

    a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (count_o == '0));

    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (count_o == '0 && !done_o));

    a_r6_done_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(frame_done_i));

    a_r5_no_step_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_done_i && !clr_i && !hold_i) |=> $stable(count_o));
endmodule

// File: rtl/sfs_select.sv
module sfs_select
    import sfs_pkg::*;
#(
    parameter int NSEL = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  ctrl_t           ctrl_i,
    input  logic            fifo_empty_i,
    input  logic            msg_end_i,
    input  logic [NSEL-1:0] bits_i,
    input  logic            direct_i,
    input  logic            oe_i,
    output logic [NSEL-1:0] sel_o,
    output logic            sel_oe_o
);
    typedef struct packed {
        logic msg;
    } sel_st_t;

    sel_st_t s_d, s_q;
    logic    live;
    logic    act;

    assign live = ctrl_i.en && !ctrl_i.hold_rst;

    always_comb begin
        s_d = s_q;
        if (!live || msg_end_i) s_d.msg = 1'b0;
        else if (!fifo_empty_i) s_d.msg = 1'b1;
        act = live && (!fifo_empty_i || (ctrl_i.sticky && s_q.msg));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sel_o    = direct_i ? bits_i : ~(act ? bits_i : '0);
    assign sel_oe_o = oe_i;

    // R12: queued data under sticky select keeps the selects asserted next cycle
    a_r12_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (live && ctrl_i.sticky && !direct_i && !fifo_empty_i && !msg_end_i)
        |=> (!ctrl_i.en || ctrl_i.hold_rst || !ctrl_i.sticky || direct_i ||
             sel_o == ~bits_i));
endmodule

// File: rtl/spi_frame_sel_ctl.sv
module spi_frame_sel_ctl
    import sfs_pkg::*;
#(
    parameter int NSEL        = 8,
    parameter int FSIZE_W     = 6,
    parameter int FSIZE_RST   = 8,
    parameter int DEPTH_SMALL = 8,
    parameter int DEPTH_BIG   = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             reg_we_i,
    input  logic [2:0]                       reg_addr_i,
    input  logic [31:0]                      reg_wdata_i,
    output logic [31:0]                      reg_rdata_o,
    input  logic                             frame_done_i,
    input  logic                             txfifo_empty_i,
    output logic [31:0]                      frame_count_o,
    output logic                             done_o,
    output logic [FSIZE_W-1:0]               frame_size_o,
    output logic [$clog2(DEPTH_BIG+1)-1:0]   fifo_depth_o,
    output logic                             bus_oe_o,
    output logic [NSEL-1:0]                  sel_o,
    output logic                             sel_oe_o
);
    localparam int DEPTH_W = $clog2(DEPTH_BIG + 1);

    ctrl_t            ctrl;
    logic [31:0]      target;
    logic [NSEL-1:0]  bits;
    logic             direct;
    logic             oe;
    logic             clr;
    logic             last;

    sfs_regs #(.NSEL(NSEL), .FSIZE_W(FSIZE_W), .FSIZE_RST(FSIZE_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .ctrl_o(ctrl),
        .target_o(target), .fsize_o(frame_size_o), .bits_o(bits),
        .direct_o(direct), .oe_o(oe), .clr_o(clr)
    );

    sfs_frame_counter #(.CNT_W(32)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_i(ctrl.en), .hold_i(ctrl.hold_rst),
        .clr_i(clr), .frame_done_i(frame_done_i), .target_i(target),
        .count_o(frame_count_o), .done_o(done_o), .last_o(last)
    );

    sfs_select #(.NSEL(NSEL)) u_sel (
        .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .fifo_empty_i(txfifo_empty_i),
        .msg_end_i(last), .bits_i(bits), .direct_i(direct), .oe_i(oe),
        .sel_o(sel_o), .sel_oe_o(sel_oe_o)
    );

    assign bus_oe_o     = ctrl.en;
    assign fifo_depth_o = ctrl.big_fifo ? DEPTH_W'(DEPTH_BIG) : DEPTH_W'(DEPTH_SMALL);

    // R11: a disabled core in hardware mode leaves every select inactive
    a_r11_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_oe_o && !direct) |-> (sel_o == {NSEL{1'b1}}));
endmodule

// File: tb/tb_spi_frame_sel_ctl.sv
module tb_spi_frame_sel_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic        frame_done = 1'b0;
    logic        fifo_empty = 1'b1;
    logic [31:0] rdata;
    logic [31:0] fcount;
    logic        done;
    logic [5:0]  fsize;
    logic [5:0]  depth;
    logic        bus_oe;
    logic [7:0]  sel;
    logic        sel_oe;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    spi_frame_sel_ctl dut (
        .clk(clk), .rst_n(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata), .frame_done_i(frame_done),
        .txfifo_empty_i(fifo_empty), .frame_count_o(fcount), .done_o(done),
        .frame_size_o(fsize), .fifo_depth_o(depth), .bus_oe_o(bus_oe),
        .sel_o(sel), .sel_oe_o(sel_oe)
    );

    // behavioural reference
    bit        m_en, m_hold, m_sticky, m_big, m_dir, m_oe, m_done, m_busy;
    bit [31:0] m_target, m_cnt;
    bit [5:0]  m_fsize;
    bit [7:0]  m_bits;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en <= 0; m_hold <= 0; m_sticky <= 0; m_big <= 0; m_dir <= 0; m_oe <= 0;
            m_done <= 0; m_busy <= 0; m_target <= 0; m_cnt <= 0; m_fsize <= 8; m_bits <= 0;
        end else begin
            bit wipe, fin;
            wipe = reg_we && (reg_addr == 0 || (reg_addr == 1 && reg_wdata[0]));
            fin = m_en && !m_hold && !wipe && frame_done && (m_cnt + 1 == m_target);
            if (reg_we) begin
                if (reg_addr == 0) begin
                    {m_big, m_sticky, m_hold, m_en} <= reg_wdata[3:0];
                    m_target[15:0] <= reg_wdata[31:16];
                end
                if (reg_addr == 2 && !m_en) m_fsize <= reg_wdata[5:0];
                if (reg_addr == 3) m_target[31:16] <= reg_wdata[31:16];
                if (reg_addr == 4) begin
                    m_bits <= reg_wdata[7:0]; m_dir <= reg_wdata[8]; m_oe <= reg_wdata[9];
                end
            end
            if (m_hold || wipe) m_cnt <= 0;
            else if (m_en && frame_done) m_cnt <= m_cnt + 1;
            m_done <= fin;
            if (!m_en || m_hold || fin) m_busy <= 0;
            else if (!fifo_empty) m_busy <= 1;
        end
    end

    function automatic logic [31:0] exp_rdata();
        case (reg_addr)
            0: return {m_target[15:0], 12'b0, m_big, m_sticky, m_hold, m_en};
            2: return {26'b0, m_fsize};
            3: return m_target;
            4: return {22'b0, m_oe, m_dir, m_bits};
            default: return 0;
        endcase
    endfunction

    function automatic logic [7:0] exp_sel();
        bit on;
        on = m_en && !m_hold && (!fifo_empty || (m_sticky && m_busy));
        if (m_dir) return m_bits;
        return on ? ~m_bits : 8'hFF;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #4;
        if (rst_n) begin
            chk("R2 readback", rdata, exp_rdata());
            chk("R5 count", fcount, m_cnt);
            chk("R6 done", {31'b0, done}, {31'b0, m_done});
            chk("R11 select", {24'b0, sel}, {24'b0, exp_sel()});
            chk("R13 select oe", {31'b0, sel_oe}, {31'b0, m_oe});
            chk("R9 bus oe", {31'b0, bus_oe}, {31'b0, m_en});
            chk("R14 depth", {26'b0, depth}, m_big ? 32'd32 : 32'd8);
            chk("R8 size", {26'b0, fsize}, {26'b0, m_fsize});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 0; reg_wdata = 0;
    endtask

    task automatic rd(input logic [2:0] a, input string tag, input logic [31:0] exp);
        reg_addr = a; #1; chk(tag, rdata, exp);
    endtask

    task automatic frame();
        @(negedge clk); frame_done = 1;
        @(negedge clk); frame_done = 0; #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        // R1 reset state
        rd(0, "R1 ctrl", 0); rd(2, "R1 fsize", 8); rd(4, "R1 sel", 0); rd(3, "R1 cnthi", 0);
        chk("R1 count", fcount, 0); chk("R1 sel lines", {24'b0, sel}, 32'hFF);
        chk("R1 sel oe", {31'b0, sel_oe}, 0); chk("R1 bus oe", {31'b0, bus_oe}, 0);
        chk("R1 depth", {26'b0, depth}, 8);
        // R8 accepted while disabled
        wr(2, 32'h5); rd(2, "R8 write while disabled", 5);
        // R2 control fields and target low half
        wr(0, 32'h0003_0001); rd(0, "R2 ctrl readback", 32'h0003_0001);
        chk("R9 bus oe enabled", {31'b0, bus_oe}, 1);
        // R8 ignored while enabled
        wr(2, 32'hC); rd(2, "R8 write while enabled", 5);
        // R3 upper count keeps low half
        wr(3, 32'h0000_FFFF); rd(3, "R3 low half kept", 32'h0000_0003);
        // R5, R6 counting to target 3
        frame(); frame();
        chk("R5 two frames", fcount, 2); chk("R6 no early done", {31'b0, done}, 0);
        frame();
        chk("R6 done pulse", {31'b0, done}, 1); chk("R5 three frames", fcount, 3);
        @(negedge clk); #1; chk("R6 done one cycle", {31'b0, done}, 0);
        // R5 ignored while disabled
        wr(0, 32'h0003_0000); frame(); chk("R5 disabled no count", fcount, 0);
        // R4 command clear
        wr(0, 32'h000A_0001); frame(); frame(); chk("R4 before clear", fcount, 2);
        wr(1, 32'h1); chk("R4 command clear", fcount, 0); rd(1, "R4 command reads 0", 0);
        frame(); wr(1, 32'h0); chk("R4 command bit0 clear no effect", fcount, 1);
        wr(0, 32'h000A_0001); chk("R4 control write clears", fcount, 0);
        // R7 hold
        wr(4, 32'h0000_0203); wr(0, 32'h000A_0003);
        @(negedge clk); fifo_empty = 0; #1;
        chk("R7 hold select idle", {24'b0, sel}, 32'hFF);
        frame(); chk("R7 hold count", fcount, 0);
        @(negedge clk); fifo_empty = 1;
        // R10, R13 direct mode
        wr(4, 32'h0000_03A5); #1;
        chk("R10 direct lines", {24'b0, sel}, 32'hA5); chk("R13 oe bit", {31'b0, sel_oe}, 1);
        @(negedge clk); fifo_empty = 0; #1; chk("R10 direct ignores fifo", {24'b0, sel}, 32'hA5);
        @(negedge clk); fifo_empty = 1;
        // R11 hardware mode, not sticky
        wr(4, 32'h0000_0003); wr(0, 32'h000A_0001); #1;
        chk("R11 empty idle", {24'b0, sel}, 32'hFF); chk("R13 oe off", {31'b0, sel_oe}, 0);
        @(negedge clk); fifo_empty = 0; #1; chk("R11 data asserts", {24'b0, sel}, 32'hFC);
        @(negedge clk); fifo_empty = 1; #1; chk("R11 underrun releases", {24'b0, sel}, 32'hFF);
        // R12 sticky select through underrun
        wr(0, 32'h0002_0005);
        @(negedge clk); fifo_empty = 0;
        @(negedge clk); fifo_empty = 1; #1; chk("R12 held through empty", {24'b0, sel}, 32'hFC);
        frame(); chk("R12 held after first frame", {24'b0, sel}, 32'hFC);
        @(negedge clk); frame_done = 1; #1; chk("R12 held in final frame", {24'b0, sel}, 32'hFC);
        @(negedge clk); frame_done = 0; #1; chk("R12 released after message", {24'b0, sel}, 32'hFF);
        // R14 big fifo
        wr(0, 32'h0002_0008); #1; chk("R14 big depth", {26'b0, depth}, 32);
        // R3 full readback
        wr(3, 32'h1234_0000); rd(3, "R3 full target", 32'h1234_0002);
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule